// File: doc/BRIEF.md
# Dominant Transmit Timeout Guard

This block sits in the transmit path of a single-wire bus transceiver. It is placed between the synchronized transmit-data input and the enable of the bus driver. A low transmit-data level asks for a dominant bus. A high level, which is also what an undriven pin settles to, gives recessive.

The guard counts how many clock cycles transmit data has been held low without a break. When that count reaches a limit chosen by the operating mode, the guard withdraws the driver enable, even though transmit data is still low. A longer limit applies in the high-voltage wake mode than in the normal and fast modes. The driver stays off until transmit data goes high again. The next low level then starts a fresh, full window with no added delay.

A sticky fault flag records that a timeout took place. It stays set until a clear input is asserted. In sleep mode, or whenever the transmit-allowed input is low, the driver is never enabled and the timer is held at zero.

Top module: `dom_timeout_guard`

## Requirements
- R1: When `txd` is 1, `drv_en` is 0 in the same cycle. When `txd` is 0 in an active mode with transmit allowed and no timeout, `drv_en` is 1 in the same cycle.
- R2: `mode` is encoded as follows: 2'b00 sleep, 2'b01 fast, 2'b10 wake, 2'b11 normal. In sleep, `drv_en` is 0 for any `txd`, and no fault is raised.
- R3: While `tx_allow` is 0, `drv_en` is 0, the low-time timer is held at zero and no fault is raised.
- R4: During a continuous low of `txd` in an active, allowed mode, `drv_en` is 1 until the rising clock edge that completes LIM_STD cycles (fast and normal modes) or LIM_WAKE cycles (wake mode). From that edge on it is 0.
- R5: Once the drive has been cut, it stays cut for as long as `txd` stays low and the block stays active. This holds even if `mode` changes to one with a longer limit.
- R6: The first cycle of a new low, after `txd` has been high for at least one clock edge, enables `drv_en` at once and grants a full new window.
- R7: `fault` rises on the clock edge that follows the first cycle in which the drive was withheld by timeout. It then stays 1 until `fault_clr` is sampled 1 on a cycle with no timeout cut in progress. A cut in the same cycle wins over the clear.
- R8: The timer saturates, so `drv_en` stays 0 however long `txd` stays stuck low.
- R9: Entering sleep or dropping `tx_allow` during a low resets the timer. When the block becomes active again with `txd` still low, a full new window begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txd | input | 1 | Synchronized transmit data, 0 = dominant request |
| mode | input | 2 | Operating mode (00 sleep, 01 fast, 10 wake, 11 normal) |
| tx_allow | input | 1 | Transmission permitted when 1 |
| fault_clr | input | 1 | Clears the sticky fault flag |
| drv_en | output | 1 | Bus driver enable |
| fault | output | 1 | Sticky timeout fault flag |

## Verification
The hardest situation to reach from the ports is a wrapped timer after a very long stuck-low input. With the real millisecond-scale limits it would take millions of cycles to get there. The bench therefore builds the guard with limits of 6 and 9 cycles, so the timer is only four bits wide. It then holds `txd` low for several times the counter range and checks that the drive never returns. It also cuts the drive in normal mode and then switches to wake mode while the cut is in force, so that the longer limit cannot re-enable the driver.

// File: rtl/dom_timeout_guard_pkg.sv
package dom_timeout_guard_pkg;

    typedef enum logic [1:0] {
        MODE_SLEEP = 2'b00,
        MODE_FAST  = 2'b01,
        MODE_WAKE  = 2'b10,
        MODE_NORM  = 2'b11
    } tx_mode_e;

    typedef struct packed {
        logic cut;
        logic fault;
    } guard_state_t;

endpackage

// File: rtl/dtg_limit_sel.sv
module dtg_limit_sel
    import dom_timeout_guard_pkg::*;
#(
    parameter int LIM_STD  = 2_500_000,
    parameter int LIM_WAKE = 3_750_000,
    parameter int CNT_W    = 22
) (
    input  logic [1:0]       mode,
    output logic [CNT_W-1:0] limit,
    output logic             awake
);

    always_comb begin
        limit = CNT_W'(LIM_STD);
        awake = 1'b1;
        case (tx_mode_e'(mode))
            MODE_SLEEP: begin
                awake = 1'b0;
            end
            MODE_WAKE: begin
                limit = CNT_W'(LIM_WAKE);
            end
            default: begin
                limit = CNT_W'(LIM_STD);
            end
        endcase
    end

endmodule

// File: rtl/dtg_low_timer.sv
module dtg_low_timer #(
    parameter int CNT_MAX = 3_750_000,
    parameter int CNT_W   = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [CNT_W-1:0] cnt_q
);

    localparam logic [CNT_W-1:0] TOP = CNT_W'(CNT_MAX);

    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q < TOP) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R8: a saturated timer holds its value while the low persists
    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == TOP && run) |=> (cnt_q == TOP));

    // R9: any break in the low clears the timer on the next edge
    p_timer_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/dom_timeout_guard.sv
module dom_timeout_guard
    import dom_timeout_guard_pkg::*;
#(
    parameter int LIM_STD  = 2_500_000,
    parameter int LIM_WAKE = 3_750_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       txd,
    input  logic [1:0] mode,
    input  logic       tx_allow,
    input  logic       fault_clr,
    output logic       drv_en,
    output logic       fault
);

    localparam int CNT_MAX = (LIM_WAKE > LIM_STD) ? LIM_WAKE : LIM_STD;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    guard_state_t     st_d, st_q;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt_q;
    logic             awake;
    logic             active;
    logic             run;
    logic             expired;
    logic             cut;

    dtg_limit_sel #(
        .LIM_STD (LIM_STD),
        .LIM_WAKE(LIM_WAKE),
        .CNT_W   (CNT_W)
    ) u_limit (
        .mode (mode),
        .limit(limit),
        .awake(awake)
    );

    dtg_low_timer #(
        .CNT_MAX(CNT_MAX),
        .CNT_W  (CNT_W)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .cnt_q(cnt_q)
    );

    always_comb begin
        active   = awake & tx_allow;
        run      = active & ~txd;
        expired  = (cnt_q >= limit);
        cut      = run & (st_q.cut | expired);
        drv_en   = run & ~cut;
        st_d.cut   = cut;
        st_d.fault = cut | (st_q.fault & ~fault_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault = st_q.fault;

    // R1: recessive request never drives
    p_txd_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        txd |-> !drv_en);

    // R2: sleep never drives
    p_sleep_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SLEEP) |-> !drv_en);

    // R3: no drive without permission
    p_allow_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_allow |-> !drv_en);

    // R5: a withheld drive stays withheld through a continuing low
    p_stay_cut_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run && !drv_en) && run) |-> !drv_en);

    // R6: a fresh low always starts with the driver enabled
    p_fresh_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !$past(run)) |-> drv_en);

    // R7: fault is sticky until cleared
    p_fault_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !fault_clr) |=> fault);

endmodule

// File: tb/dom_timeout_guard_test.sv
module dom_timeout_guard_test;

    localparam int LS = 6;
    localparam int LW = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txd = 1'b1;
    logic [1:0] mode = 2'b00;
    logic       tx_allow = 1'b0;
    logic       fault_clr = 1'b0;
    logic       drv_en;
    logic       fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dom_timeout_guard #(.LIM_STD(LS), .LIM_WAKE(LW)) uut (
        .clk(clk), .rst_n(rst_n), .txd(txd), .mode(mode),
        .tx_allow(tx_allow), .fault_clr(fault_clr),
        .drv_en(drv_en), .fault(fault)
    );

    task automatic chk(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    function automatic int lim_of(input logic [1:0] m);
        return (m == 2'b10) ? LW : LS;
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle();
        txd = 1'b1;
        fault_clr = 1'b1;
        step();
        fault_clr = 1'b0;
        step();
    endtask

    // Hold txd low for n edges; check drive each cycle, then fault afterwards.
    task automatic run_low(input logic [1:0] m, input logic al, input int n);
        bit act;
        int lim;
        act = (m != 2'b00) && al;
        lim = lim_of(m);
        mode = m;
        tx_allow = al;
        txd = 1'b0;
        for (int k = 0; k <= n; k++) begin
            #1;
            // R1 R2 R3 R4: drive during first lim cycles only, and only when active
            chk(drv_en, act && (k < lim), act ? "R4" : (m == 2'b00 ? "R2" : "R3"));
            if (k < n) step();
        end
        txd = 1'b1;
        #1;
        chk(drv_en, 1'b0, "R1");
        step();
        #1;
        // R7: fault set only if an edge saw the cut (k >= lim+1 edges)
        chk(fault, act && (n >= lim + 1), act ? "R7" : "R3");
        idle();
        #1;
        chk(fault, 1'b0, "R7");
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step();
        #1;
        chk(drv_en, 1'b0, "R1");
        chk(fault, 1'b0, "R7");
        rst_n = 1'b1;
        idle();

        // Sweep every mode, permission and low length.
        for (int m = 0; m < 4; m++) begin
            for (int al = 0; al < 2; al++) begin
                for (int n = 0; n <= LW + 3; n++) begin
                    run_low(2'(m), al[0], n);
                end
            end
        end

        // R5: cut in normal, then switch to wake mode: stays cut
        mode = 2'b11; tx_allow = 1'b1; txd = 1'b0;
        for (int k = 0; k < LS + 2; k++) step();
        mode = 2'b10;
        for (int k = 0; k < 4; k++) begin
            #1;
            chk(drv_en, 1'b0, "R5");
            step();
        end
        // R7: clear while cut is in progress loses to the cut
        fault_clr = 1'b1;
        step();
        #1;
        chk(fault, 1'b1, "R7");
        fault_clr = 1'b0;
        // R6: brief high then low re-enables immediately with full window
        txd = 1'b1;
        step();
        txd = 1'b0;
        for (int k = 0; k <= LW; k++) begin
            #1;
            chk(drv_en, k < LW, "R6");
            step();
        end
        idle();

        // R9: sleep interruption resets timer
        mode = 2'b10; txd = 1'b0;
        for (int k = 0; k < 5; k++) step();
        mode = 2'b00;
        #1;
        chk(drv_en, 1'b0, "R2");
        step();
        mode = 2'b10;
        for (int k = 0; k <= LW; k++) begin
            #1;
            chk(drv_en, k < LW, "R9");
            step();
        end
        idle();
        // R9: permission drop resets timer too
        mode = 2'b01; txd = 1'b0;
        for (int k = 0; k < 4; k++) step();
        tx_allow = 1'b0;
        step();
        tx_allow = 1'b1;
        for (int k = 0; k <= LS; k++) begin
            #1;
            chk(drv_en, k < LS, "R9");
            step();
        end
        idle();

        // R8: very long stuck low, far past the timer range
        mode = 2'b11; txd = 1'b0;
        for (int k = 0; k < 80; k++) begin
            #1;
            chk(drv_en, k < LS, "R8");
            step();
        end
        #1;
        chk(fault, 1'b1, "R7");
        idle();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule